// File: doc/BRIEF.md
# Timer Capture/Compare/PWM Channel

This block is one channel of a general-purpose timer, with the up counter and its modulo register built in. A processor reaches it over a byte-wide register bus. The channel has four modes: input capture, output compare, edge-aligned PWM and center-aligned PWM. In capture mode the channel stores the counter value when the selected edge appears on its pin. In compare mode it changes its pin when the counter reaches a programmed value. In the two PWM modes it drives a pulse whose width is set by the channel value register. Every mode reports through a single event flag. The flag can raise an interrupt request.

The flag has a guarded clear. Software first reads the status/control register while the flag is set, then writes a zero to the flag bit. If a new event arrives between that read and that write, the clear is cancelled, so an event is never lost.

Register offsets on the 3-bit address: 0 control (bit 0 = center-PWM select), 1/2 counter high/low, 3/4 modulo high/low, 5 status/control, 6/7 channel value high/low. Status/control bit layout: 7 event flag, 6 interrupt enable, 5 mode bit B, 4 mode bit A, 3:2 edge/level bits B:A, 1:0 reserved.

Top module: `tmr_chan`

## Requirements
- R1: After reset, status/control reads 0x00, control reads 0x00, modulo reads 0xFFFF, the channel value reads 0x0000, and both irq_o and pin_oe_o are low.
- R2: The mode is chosen as follows. Center-PWM select = 1 gives center-aligned PWM. Otherwise, mode bit B = 1 gives edge-aligned PWM. With B = 0, mode bit A = 0 gives input capture and A = 1 gives output compare.
- R3: In the non-center modes the counter counts 0, 1, …, modulo, then 0 again. In center-aligned mode it counts up to the modulo value and then back down to 0. A write to either counter byte restarts it at 0 and counts up. The counter bytes read back the live count.
- R4: In input capture mode, edge/level 01 selects rising edges, 10 falling edges and 11 both. The pin passes through two synchronizer flops. When the selected edge is taken, the flag sets and the counter value is latched into the channel value register. Both happen three clocks after the pin changes, and the latched value is the count two clocks after the change.
- R5: In output compare mode, a counter-to-value match sets the flag one clock later. At the same clock the pin goes to: 01 toggle, 10 low, 11 high.
- R6: In edge-aligned PWM mode, the pin is "count < value", delayed by one clock. It is active-high for edge/level 10 and inverted for x1. Value 0 gives no active time and value modulo+1 gives full active time. A match sets the flag one clock later.
- R7: Center-aligned PWM uses the same pin rule as R6. The flag sets after every match, so it sets once on the up-slope and once on the down-slope.
- R8: irq_o is high exactly while the flag and the interrupt enable are both 1.
- R9: The flag clears only when a status/control read that sees it set is followed by a status/control write with bit 7 = 0. Writing bit 7 = 1, or writing 0 with no qualifying read, leaves it set.
- R10: An event that occurs after the qualifying read and before the clearing write cancels the clear, and the flag stays set.
- R11: Edge/level 00 releases the pin (pin_oe_o low). An output-compare match still sets the flag. pin_oe_o is always low in input capture mode.
- R12: Status/control bits 1:0 always read 0.
- R13: Modulo writes, and channel value writes outside capture mode, are staged. A low-byte write commits the pair, and the new value takes effect when the counter wraps to 0 or is restarted. In capture mode a value low-byte write takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe, one clock per access |
| rd_i | input | 1 | Read strobe, one clock per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| pin_i | input | 1 | Channel pin input (asynchronous) |
| pin_o | output | 1 | Channel pin output value |
| pin_oe_o | output | 1 | Channel pin output enable |
| irq_o | output | 1 | Channel interrupt request |

## Verification
Each result has its own latency:
- Output-compare and PWM pin values, and the flag after a match, change one clock after the counter holds the matching value.
- A capture shows on the flag three clocks after the pin changes.
- A clear becomes visible the clock after the write.

The bench counts rising edges from the clock that restarts the counter. It drives inputs on the falling edge and samples at the falling edge of exactly the cycle where each result is due, so the expected count, pin level and flag state come from cycle arithmetic alone.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT_H = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT_L = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_MOD_H = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_MOD_L = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_SC    = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_VAL_H = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_VAL_L = 3'd7;

  typedef enum logic [1:0] {
    MODE_IC   = 2'd0,
    MODE_OC   = 2'd1,
    MODE_EPWM = 2'd2,
    MODE_CPWM = 2'd3
  } chan_mode_e;
endpackage

// File: rtl/tmr_chan_cnt.sv
module tmr_chan_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             center_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             down_q, down_d;
  logic             nat_wrap;

  always_comb begin
    cnt_d    = cnt_q;
    down_d   = down_q;
    nat_wrap = 1'b0;
    if (restart_i) begin
      cnt_d  = '0;
      down_d = 1'b0;
    end else if (!center_i) begin
      down_d = 1'b0;
      if (cnt_q >= mod_i) begin
        cnt_d    = '0;
        nat_wrap = 1'b1;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else if (!down_q) begin
      if (cnt_q >= mod_i) begin
        if (mod_i == '0) begin
          cnt_d    = '0;
          nat_wrap = 1'b1;
        end else begin
          cnt_d  = cnt_q - ONE;
          down_d = 1'b1;
        end
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else begin
      if (cnt_q <= ONE) begin
        cnt_d    = '0;
        down_d   = 1'b0;
        nat_wrap = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = nat_wrap | restart_i;
endmodule

// File: rtl/tmr_chan_dbuf.sv
module tmr_chan_dbuf #(
  parameter int unsigned      W     = 16,
  parameter int unsigned      BW    = 8,
  parameter logic [W-1:0]     RST_V = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_hi_i,
  input  logic          wr_lo_i,
  input  logic [BW-1:0] wdata_i,
  input  logic          direct_i,
  input  logic          load_i,
  input  logic          cap_i,
  input  logic [W-1:0]  cap_val_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] stage_q, q_q;
  logic         pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= RST_V;
      pend_q  <= 1'b0;
      q_q     <= RST_V;
    end else begin
      if (wr_hi_i) stage_q[W-1:BW] <= wdata_i;
      if (wr_lo_i) stage_q[BW-1:0] <= wdata_i;

      if (wr_lo_i && !direct_i)       pend_q <= 1'b1;
      else if (wr_lo_i || load_i)     pend_q <= 1'b0;

      if (cap_i)                      q_q <= cap_val_i;
      else if (wr_lo_i && direct_i)   q_q <= {stage_q[W-1:BW], wdata_i};
      else if (load_i && pend_q)      q_q <= stage_q;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/tmr_chan_edge.sv
module tmr_chan_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/tmr_chan_flag.sv
module tmr_chan_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic rd_sc_i,
  input  logic wr_sc_i,
  input  logic wr_zero_i,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      // a new event always wins and voids a pending clear
      if (evt_i)                                flag_q <= 1'b1;
      else if (wr_sc_i && wr_zero_i && armed_q) flag_q <= 1'b0;

      if (evt_i)                  armed_q <= 1'b0;
      else if (rd_sc_i && flag_q) armed_q <= 1'b1;
      else if (wr_sc_i)           armed_q <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int unsigned      CNT_W       = 16,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] MOD_RST     = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              pin_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              irq_o
);
  logic             center_q, ie_q, msb_q, msa_q;
  logic [1:0]       els_q;
  logic             pin_q;
  chan_mode_e       mode;
  logic [CNT_W-1:0] cnt, mod_v, val_v;
  logic             wrap, restart;
  logic             rise, fall, cap, match, evt;
  logic             flag, armed;
  logic             wr_sc, rd_sc;

  assign wr_sc   = wr_i && (addr_i == ADDR_SC);
  assign rd_sc   = rd_i && (addr_i == ADDR_SC);
  assign restart = wr_i && ((addr_i == ADDR_CNT_H) || (addr_i == ADDR_CNT_L));

  always_comb begin
    if (center_q)   mode = MODE_CPWM;
    else if (msb_q) mode = MODE_EPWM;
    else if (msa_q) mode = MODE_OC;
    else            mode = MODE_IC;
  end

  tmr_chan_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .center_i (center_q),
    .restart_i(restart),
    .mod_i    (mod_v),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  tmr_chan_dbuf #(.W(CNT_W), .BW(BUS_W), .RST_V(MOD_RST)) u_mod (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_hi_i  (wr_i && (addr_i == ADDR_MOD_H)),
    .wr_lo_i  (wr_i && (addr_i == ADDR_MOD_L)),
    .wdata_i  (wdata_i),
    .direct_i (1'b0),
    .load_i   (wrap),
    .cap_i    (1'b0),
    .cap_val_i('0),
    .q_o      (mod_v)
  );

  tmr_chan_dbuf #(.W(CNT_W), .BW(BUS_W), .RST_V('0)) u_val (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_hi_i  (wr_i && (addr_i == ADDR_VAL_H)),
    .wr_lo_i  (wr_i && (addr_i == ADDR_VAL_L)),
    .wdata_i  (wdata_i),
    .direct_i (mode == MODE_IC),
    .load_i   (wrap),
    .cap_i    (cap),
    .cap_val_i(cnt),
    .q_o      (val_v)
  );

  tmr_chan_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign cap   = (mode == MODE_IC) && ((els_q[0] && rise) || (els_q[1] && fall));
  assign match = (mode != MODE_IC) && (cnt == val_v);
  assign evt   = cap | match;

  tmr_chan_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .rd_sc_i  (rd_sc),
    .wr_sc_i  (wr_sc),
    .wr_zero_i(!wdata_i[BUS_W-1]),
    .flag_o   (flag),
    .armed_o  (armed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      center_q <= 1'b0;
      ie_q     <= 1'b0;
      msb_q    <= 1'b0;
      msa_q    <= 1'b0;
      els_q    <= 2'b00;
    end else begin
      if (wr_i && (addr_i == ADDR_CTRL)) center_q <= wdata_i[0];
      if (wr_sc) begin
        ie_q  <= wdata_i[6];
        msb_q <= wdata_i[5];
        msa_q <= wdata_i[4];
        els_q <= wdata_i[3:2];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
    end else begin
      unique case (mode)
        MODE_OC: if (match) begin
          unique case (els_q)
            2'b01:   pin_q <= ~pin_q;
            2'b10:   pin_q <= 1'b0;
            2'b11:   pin_q <= 1'b1;
            default: pin_q <= pin_q;
          endcase
        end
        MODE_EPWM, MODE_CPWM: pin_q <= (cnt < val_v) ^ els_q[0];
        default: pin_q <= pin_q;
      endcase
    end
  end

  assign pin_o    = pin_q;
  assign pin_oe_o = (mode != MODE_IC) && (els_q != 2'b00);
  assign irq_o    = flag & ie_q;

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL:  rdata_o = {{(BUS_W-1){1'b0}}, center_q};
      ADDR_CNT_H: rdata_o = cnt[CNT_W-1:BUS_W];
      ADDR_CNT_L: rdata_o = cnt[BUS_W-1:0];
      ADDR_MOD_H: rdata_o = mod_v[CNT_W-1:BUS_W];
      ADDR_MOD_L: rdata_o = mod_v[BUS_W-1:0];
      ADDR_SC:    rdata_o = {flag, ie_q, msb_q, msa_q, els_q, 2'b00};
      ADDR_VAL_H: rdata_o = val_v[CNT_W-1:BUS_W];
      default:    rdata_o = val_v[BUS_W-1:0];
    endcase
  end
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
  import tmr_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [BUS_W-1:0]  wdata_i,
  input logic [BUS_W-1:0]  rdata_o,
  input logic              pin_oe_o,
  input logic              irq_o,
  input logic              flag,
  input logic              ie,
  input logic              armed,
  input logic              evt,
  input chan_mode_e        mode,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  mod_v,
  input logic [CNT_W-1:0]  val_v
);
  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= mod_v);

  p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && mode == MODE_IC) |=> (val_v == $past(cnt)));

  p_evt_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> flag);

  p_irq_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag && ie));

  p_clear_path_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag) |-> $past(wr_i && addr_i == ADDR_SC && !wdata_i[BUS_W-1]));

  p_write_one_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_SC && wdata_i[BUS_W-1] && flag) |=> flag);

  p_cancel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && evt) |=> (flag && !armed));

  p_ic_no_drive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_IC) |-> !pin_oe_o);

  p_reserved_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_SC) |-> (rdata_o[1:0] == 2'b00));
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pin_oe_o(pin_oe_o),
  .irq_o   (irq_o),
  .flag    (flag),
  .ie      (ie_q),
  .armed   (armed),
  .evt     (evt),
  .mode    (mode),
  .cnt     (cnt),
  .mod_v   (mod_v),
  .val_v   (val_v)
);

// File: tb/tmr_chan_test.sv
module tmr_chan_test;
  import tmr_chan_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr = 1'b0, rd = 1'b0;
  logic [BUS_W-1:0]  wdata = '0;
  logic [BUS_W-1:0]  rdata;
  logic              pin_in = 1'b0;
  logic              pin_out, pin_oe, irq;

  int total = 0, bad = 0;
  int cyc = 0, c0 = 0;
  logic [7:0] d;

  tmr_chan uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc - c0);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [7:0] v);
    addr = a; wdata = v; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [7:0] v);
    addr = a; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait_k(input int k);
    while (cyc - c0 < k) @(negedge clk);
  endtask

  task automatic restart();
    bus_wr(ADDR_CNT_L, 8'h00);
    c0 = cyc;
  endtask

  // leaves the counter restarted, flag cleared, at k = 2
  task automatic setup(input logic ctr, input logic [7:0] sc, input int md, input int vl);
    logic [7:0] t;
    bus_wr(ADDR_CTRL, 8'h00);
    bus_wr(ADDR_SC, 8'h00);
    bus_wr(ADDR_VAL_H, vl[15:8]);
    bus_wr(ADDR_VAL_L, vl[7:0]);
    bus_wr(ADDR_MOD_H, md[15:8]);
    bus_wr(ADDR_MOD_L, md[7:0]);
    bus_wr(ADDR_CTRL, {7'b0, ctr});
    bus_wr(ADDR_SC, sc);
    restart();
    bus_rd(ADDR_SC, t);
    bus_wr(ADDR_SC, sc & 8'h7F);
  endtask

  function automatic int ecnt(input int k, input int m);
    return k % (m + 1);
  endfunction

  function automatic int ccnt(input int k, input int m);
    int p;
    p = k % (2 * m);
    return (p <= m) ? p : 2 * m - p;
  endfunction

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(pin_oe == 1'b0, "R1 oe", pin_oe, 0);
    bus_rd(ADDR_SC, d);   check(d == 8'h00, "R1 sc", d, 0);
    bus_rd(ADDR_CTRL, d); check(d == 8'h00, "R1 ctrl", d, 0);
    bus_rd(ADDR_MOD_H, d); check(d == 8'hFF, "R1 mod_h", d, 255);
    bus_rd(ADDR_MOD_L, d); check(d == 8'hFF, "R1 mod_l", d, 255);
    bus_rd(ADDR_VAL_H, d); check(d == 8'h00, "R1 val_h", d, 0);
    bus_rd(ADDR_VAL_L, d); check(d == 8'h00, "R1 val_l", d, 0);

    // R12 reserved bits, R9 writing 1 to flag does nothing
    bus_wr(ADDR_SC, 8'hFF);
    bus_rd(ADDR_SC, d);
    check(d == 8'h7C, "R12 reserved read", d, 8'h7C);
    bus_wr(ADDR_SC, 8'h00);

    // R3 counter sequences and readback
    setup(1'b0, 8'h00, 4, 0);
    bus_rd(ADDR_MOD_L, d); check(d == 8'd4, "R13 mod commit on restart", d, 4);
    wait_k(6);
    bus_rd(ADDR_CNT_L, d); check(d == ecnt(6, 4), "R3 edge count", d, ecnt(6, 4));
    bus_rd(ADDR_CNT_H, d); check(d == 0, "R3 count high", d, 0);
    setup(1'b1, 8'h00, 4, 0);
    bus_rd(ADDR_CTRL, d); check(d == 8'h01, "R2 center select readback", d, 1);
    wait_k(6);
    bus_rd(ADDR_CNT_L, d); check(d == ccnt(6, 4), "R3 center count down", d, ccnt(6, 4));
    wait_k(11);
    bus_rd(ADDR_CNT_L, d); check(d == ccnt(11, 4), "R3 center count up", d, ccnt(11, 4));

    // R6 edge PWM sweep, R2 mode B, R8 irq
    for (int pol = 0; pol < 2; pol++) begin
      for (int v = 0; v <= 8; v++) begin
        logic [7:0] sc;
        sc = 8'h60 | (pol ? 8'h04 : 8'h08);
        setup(1'b0, sc, 7, v);
        for (int k = 3; k <= 2 * 8 + 2; k++) begin
          bit ea, ei;
          wait_k(k);
          ea = (ecnt(k - 1, 7) < v) ^ pol[0];
          check(pin_out == ea, "R6 edge pwm pin", pin_out, ea);
          check(pin_oe == 1'b1, "R6 edge pwm oe", pin_oe, 1);
          if (v >= 2 && v <= 7) begin
            ei = (k >= v + 1);
            check(irq == ei, "R8 edge pwm irq", irq, ei);
          end
        end
      end
    end

    // R7 center PWM sweep
    for (int pol = 0; pol < 2; pol++) begin
      for (int v = 0; v <= 6; v++) begin
        logic [7:0] sc;
        sc = 8'h40 | (pol ? 8'h04 : 8'h08);
        setup(1'b1, sc, 5, v);
        for (int k = 3; k <= 2 * 10 + 2; k++) begin
          bit ea, ei;
          wait_k(k);
          ea = (ccnt(k - 1, 5) < v) ^ pol[0];
          check(pin_out == ea, "R7 center pwm pin", pin_out, ea);
          if (v >= 2 && v <= 5) begin
            ei = (k >= v + 1);
            check(irq == ei, "R7 center pwm irq", irq, ei);
          end
        end
      end
    end

    // R7 flag on both slopes: matches at k=2 and k=8
    setup(1'b1, 8'h48, 5, 2);
    wait_k(3); check(irq == 1'b1, "R7 up-slope flag", irq, 1);
    wait_k(4); bus_rd(ADDR_SC, d);
    bus_wr(ADDR_SC, 8'h48);
    wait_k(6); check(irq == 1'b0, "R9 cleared", irq, 0);
    wait_k(8); check(irq == 1'b0, "R7 before down match", irq, 0);
    wait_k(9); check(irq == 1'b1, "R7 down-slope flag", irq, 1);

    // R5 output compare actions, M=9 v=4, matches at k=4,14,24,34,44
    setup(1'b0, 8'h5C, 9, 4);
    wait_k(4); check(irq == 1'b0, "R5 no flag before match", irq, 0);
    wait_k(5); check(pin_out == 1'b1, "R5 set on match", pin_out, 1);
    check(irq == 1'b1, "R5 flag on match", irq, 1);
    check(pin_oe == 1'b1, "R5 oe", pin_oe, 1);
    wait_k(6); bus_wr(ADDR_SC, 8'h58);
    wait_k(14); check(pin_out == 1'b1, "R5 hold before clear", pin_out, 1);
    wait_k(15); check(pin_out == 1'b0, "R5 clear on match", pin_out, 0);
    wait_k(16); bus_wr(ADDR_SC, 8'h54);
    wait_k(25); check(pin_out == 1'b1, "R5 toggle up", pin_out, 1);
    wait_k(35); check(pin_out == 1'b0, "R5 toggle down", pin_out, 0);
    wait_k(36); bus_wr(ADDR_SC, 8'h50);
    wait_k(38); check(pin_oe == 1'b0, "R11 detached oe", pin_oe, 0);
    wait_k(40); bus_rd(ADDR_SC, d);
    bus_wr(ADDR_SC, 8'h50);
    wait_k(43); check(irq == 1'b0, "R11 cleared before match", irq, 0);
    wait_k(45); check(irq == 1'b1, "R11 software timer flag", irq, 1);

    // R9/R10 clear handshake, M=20 v=5, matches at k=5,26,47
    setup(1'b0, 8'h50, 20, 5);
    wait_k(6); check(irq == 1'b1, "R9 flag set", irq, 1);
    wait_k(7); bus_wr(ADDR_SC, 8'h50);
    wait_k(9); check(irq == 1'b1, "R9 write0 without read", irq, 1);
    wait_k(8); bus_rd(ADDR_SC, d);
    check(d[7] == 1'b1, "R9 flag readback", d[7], 1);
    bus_wr(ADDR_SC, 8'hD0);
    wait_k(10); check(irq == 1'b1, "R9 write one", irq, 1);
    wait_k(11); bus_rd(ADDR_SC, d);
    bus_wr(ADDR_SC, 8'h50);
    wait_k(13); check(irq == 1'b0, "R9 proper clear", irq, 0);
    wait_k(27); check(irq == 1'b1, "R9 set again", irq, 1);
    wait_k(46); bus_rd(ADDR_SC, d);
    bus_wr(ADDR_SC, 8'h50);
    wait_k(50); check(irq == 1'b1, "R10 clear cancelled", irq, 1);
    wait_k(51); bus_rd(ADDR_SC, d);
    bus_wr(ADDR_SC, 8'h50);
    wait_k(53); check(irq == 1'b0, "R10 later clear works", irq, 0);
    bus_wr(ADDR_SC, 8'h10);
    check(irq == 1'b0, "R8 enable off", irq, 0);

    // R13 staged value: write at k=2 takes effect at wrap k=8
    setup(1'b0, 8'h68, 7, 3);
    bus_wr(ADDR_VAL_L, 8'd6);
    wait_k(5);  check(pin_out == 1'b0, "R13 old value still used", pin_out, 0);
    wait_k(7);  check(pin_out == 1'b0, "R13 old value late", pin_out, 0);
    wait_k(12); check(pin_out == 1'b1, "R13 new value after wrap", pin_out, 1);

    // R4 input capture sweep: edge select x pin direction
    for (int e = 0; e < 4; e++) begin
      for (int dir = 0; dir < 2; dir++) begin
        bit exp_evt;
        logic [7:0] vh, vl;
        int exp_val;
        pin_in = dir ? 1'b1 : 1'b0;
        repeat (5) @(negedge clk);
        setup(1'b0, 8'h40 | 8'(e << 2), 200, 16'hA5A5);
        exp_evt = dir ? e[1] : e[0];
        wait_k(5);
        pin_in = ~pin_in;
        wait_k(7);
        check(irq == 1'b0, "R4 no early capture", irq, 0);
        check(pin_oe == 1'b0, "R11 capture oe", pin_oe, 0);
        wait_k(8);
        check(irq == exp_evt, "R4 capture flag", irq, exp_evt);
        bus_rd(ADDR_VAL_H, vh);
        bus_rd(ADDR_VAL_L, vl);
        exp_val = exp_evt ? 7 : 16'hA5A5;
        check({vh, vl} == exp_val[15:0], "R4 captured value", {vh, vl}, exp_val);
      end
    end
    pin_in = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule